// File: doc/BRIEF.md
# Card Operation Timeout Supervisor

This block watches a single outstanding read, write or erase operation on a storage card and reports whether the card finished in time. When the host controller signals the start of an operation, the block works out the typical duration of that operation in clock cycles. It uses the card's access-time figures, its write-speed multiplier and, for erases, the number of erase groups. It then allows ten times that duration before it declares the card unresponsive.

While the operation is outstanding, `busy` is high. If the completion strobe arrives in time, `busy` drops and `done_pulse` fires for one cycle. If the allowance runs out first, `busy` drops and `timed_out` rises and stays high. The host then treats the card as hung and resets it. Decoding the timing fields out of the card's configuration register is done elsewhere; this block receives them already expressed in cycles.

Top module: `op_timeout_wdog`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done_pulse` and `timed_out` are all low.
- R2: For a read (`op_kind` = 0), the allowance L is 10 × (`taac_cyc` + `nsac_cyc`) clock cycles.
- R3: For a write (`op_kind` = 1), the allowance is 10 × (`taac_cyc` + `nsac_cyc`) × 2^`r2w_code`, where `r2w_code` is 0 to 5.
- R4: For an erase (`op_kind` = 2), the allowance is 10 × `erase_groups` × the write-time product of R3.
- R5: All timing inputs are captured on the accepting edge. Changing them while `busy` is high does not alter the running allowance.
- R6: A completion strobe during `busy` clears `busy` on the next edge and pulses `done_pulse` high for exactly one cycle, with `timed_out` staying low. A strobe arriving on the final counted cycle still counts as a completion.
- R7: Without a completion, `busy` stays high for exactly L cycles after the accepting edge. It then falls, and `timed_out` rises and holds until the next accepted start.
- R8: Every stage of the allowance arithmetic saturates at 2^CNT_W − 1. An allowance of zero behaves like an allowance of one.
- R9: A start strobe while `busy` is high is ignored. A completion strobe while idle is ignored.
- R10: A start with `op_kind` = 3 is not accepted and leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start strobe for a new operation |
| op_kind | input | 2 | 0 read, 1 write, 2 erase, 3 reserved |
| taac_cyc | input | ACC_W | Access time converted to clock cycles |
| nsac_cyc | input | NSAC_W | Additional access cycles |
| r2w_code | input | 3 | Write multiplier exponent |
| erase_groups | input | EG_W | Number of erase groups in the operation |
| op_done_in | input | 1 | Completion strobe from the card side |
| busy | output | 1 | Operation outstanding |
| done_pulse | output | 1 | One-cycle completion indication |
| timed_out | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with CNT_W = 12, ACC_W = 10, NSAC_W = 8 and EG_W = 4. With a 4095-cycle ceiling, saturation of the shift, the multiply and the final scale by ten can all be reached in a short run. This includes a write whose unsaturated allowance would be 80000 cycles. The narrow erase-group field also makes the zero-group case, and the zero-allowance behaviour that follows from it, easy to drive next to ordinary read, write and erase allowances of tens to hundreds of cycles.

// File: rtl/op_wdog_pkg.sv
// Package: shared operation codes and the scale factor for the timeout supervisor.
// Assumes: op_kind encoding is fixed by the interface (0 read, 1 write, 2 erase).
package op_wdog_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_kind_e;

    localparam int unsigned TIMEOUT_SCALE = 10;
    localparam int unsigned R2W_MAX_CODE  = 5;
endpackage

// File: rtl/op_limit_calc.sv
// Module: op_limit_calc
// Computes the timeout allowance for one operation as a purely combinational function
// of the card timing inputs. Each stage (read time, write time, erase time,
// scaled limit) saturates at 2^CNT_W-1.
// Assumes: ACC_W and NSAC_W are below CNT_W; r2w_code above 5 is clamped to 5.
module op_limit_calc
    import op_wdog_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int NSAC_W = 8,
    parameter int EG_W   = 16,
    parameter int CNT_W  = 40
) (
    input  logic [1:0]        kind,
    input  logic [ACC_W-1:0]  taac,
    input  logic [NSAC_W-1:0] nsac,
    input  logic [2:0]        r2w,
    input  logic [EG_W-1:0]   groups,
    output logic [CNT_W-1:0]  limit
);
    localparam int WIDE_W = CNT_W + EG_W + 6;
    localparam logic [WIDE_W-1:0] SAT_WIDE = {{(WIDE_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] read_t, write_t, erase_t, typ_t;
    logic [2:0]       r2w_eff;

    // Clamp a wide intermediate to the counter range.
    function automatic logic [CNT_W-1:0] sat(input logic [WIDE_W-1:0] v);
        return (v > SAT_WIDE) ? {CNT_W{1'b1}} : v[CNT_W-1:0];
    endfunction

    // Per-stage saturating arithmetic for the typical times.
    always_comb begin
        r2w_eff = (r2w > 3'(R2W_MAX_CODE)) ? 3'(R2W_MAX_CODE) : r2w;
        read_t  = sat(WIDE_W'(taac) + WIDE_W'(nsac));
        write_t = sat(WIDE_W'(read_t) << r2w_eff);
        erase_t = sat(WIDE_W'(write_t) * WIDE_W'(groups));
    end

    // Select the typical time for the operation kind and scale it.
    always_comb begin
        unique case (op_kind_e'(kind))
            OP_READ:  typ_t = read_t;
            OP_WRITE: typ_t = write_t;
            OP_ERASE: typ_t = erase_t;
            default:  typ_t = '0;
        endcase
        limit = sat(WIDE_W'(typ_t) * WIDE_W'(TIMEOUT_SCALE));
    end

    // Stage relations that must survive saturation.
    always_comb begin
        p_write_ge_read_r3: assert (write_t >= read_t);
        p_zero_groups_r4:   assert ((groups != '0) || (erase_t == '0));
    end
endmodule

// File: rtl/op_elapsed_timer.sv
// Module: op_elapsed_timer
// Holds the latched limit and counts the cycles an operation has been outstanding.
// Raises 'expire' on the cycle whose edge would complete the allowance.
// Assumes: 'load' and 'run' are never high together (the controller only loads when idle).
module op_elapsed_timer #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] limit_in,
    output logic             expire
);
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    // Capture the limit at start and advance the elapsed count while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            limit_q <= limit_in;
            cnt_q   <= '0;
        end else if (run && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry when the next counted cycle reaches the limit (a zero limit acts as one).
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        expire  = run && (cnt_inc >= {1'b0, limit_q});
    end

    p_limit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> $stable(limit_q));
    p_cnt_below_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (limit_q != '0)) |-> (cnt_q < limit_q));
endmodule

// File: rtl/op_timeout_wdog.sv
// Module: op_timeout_wdog (top)
// Supervises one card operation at a time: computes its allowance on start,
// tracks completion, and reports done or a sticky timeout.
// Assumes: op_start and op_done_in are synchronous single-cycle strobes.
module op_timeout_wdog
    import op_wdog_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int NSAC_W = 8,
    parameter int EG_W   = 16,
    parameter int CNT_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [ACC_W-1:0]  taac_cyc,
    input  logic [NSAC_W-1:0] nsac_cyc,
    input  logic [2:0]        r2w_code,
    input  logic [EG_W-1:0]   erase_groups,
    input  logic              op_done_in,
    output logic              busy,
    output logic              done_pulse,
    output logic              timed_out
);
    logic [CNT_W-1:0] limit_w;
    logic             accept;
    logic             expire;

    op_limit_calc #(
        .ACC_W (ACC_W),
        .NSAC_W(NSAC_W),
        .EG_W  (EG_W),
        .CNT_W (CNT_W)
    ) u_calc (
        .kind  (op_kind),
        .taac  (taac_cyc),
        .nsac  (nsac_cyc),
        .r2w   (r2w_code),
        .groups(erase_groups),
        .limit (limit_w)
    );

    op_elapsed_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .run     (busy),
        .limit_in(limit_w),
        .expire  (expire)
    );

    // A start is taken only when idle and with a defined operation kind.
    always_comb begin
        accept = op_start && !busy && (op_kind_e'(op_kind) != OP_RSVD);
    end

    // Operation state: busy, completion pulse and sticky timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done_pulse <= 1'b0;
            timed_out  <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (accept) begin
                busy      <= 1'b1;
                timed_out <= 1'b0;
            end else if (busy) begin
                if (op_done_in) begin
                    busy       <= 1'b0;
                    done_pulse <= 1'b1;
                end else if (expire) begin
                    busy      <= 1'b0;
                    timed_out <= 1'b1;
                end
            end
        end
    end

    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    p_done_not_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !timed_out);
    p_timeout_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (timed_out && !accept) |=> timed_out);
    p_idle_done_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accept) |=> (!busy && !done_pulse));
endmodule

// File: tb/op_timeout_wdog_tb_top.sv
module op_timeout_wdog_tb_top;
    localparam int ACC_W = 10, NSAC_W = 8, EG_W = 4, CNT_W = 12;
    localparam longint SATV = 4095;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 1'b0;
    logic [1:0] op_kind = '0;
    logic [ACC_W-1:0] taac_cyc = '0;
    logic [NSAC_W-1:0] nsac_cyc = '0;
    logic [2:0] r2w_code = '0;
    logic [EG_W-1:0] erase_groups = '0;
    logic op_done_in = 1'b0;
    logic busy, done_pulse, timed_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit model_live = 0;

    always #2.5 clk = ~clk;

    op_timeout_wdog #(.ACC_W(ACC_W), .NSAC_W(NSAC_W), .EG_W(EG_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .taac_cyc(taac_cyc), .nsac_cyc(nsac_cyc), .r2w_code(r2w_code),
        .erase_groups(erase_groups), .op_done_in(op_done_in),
        .busy(busy), .done_pulse(done_pulse), .timed_out(timed_out));

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint satf(input longint v);
        return (v > SATV) ? SATV : v;
    endfunction

    function automatic longint allowance(input int k, input longint t, input longint n,
                                         input int c, input longint g);
        longint r, w, e, typ;
        r = satf(t + n);
        w = satf(r * (longint'(1) << ((c > 5) ? 5 : c)));
        e = satf(w * g);
        typ = (k == 0) ? r : (k == 1) ? w : e;
        return satf(typ * 10);
    endfunction

    // Behavioural reference model, stepped on every rising edge.
    bit m_busy = 0, m_done = 0, m_to = 0;
    longint m_cnt = 0, m_lim = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_to = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (op_start && !m_busy && op_kind != 2'd3) begin
                m_busy = 1; m_to = 0; m_cnt = 0;
                m_lim = allowance(op_kind, taac_cyc, nsac_cyc, r2w_code, erase_groups);
            end else if (m_busy) begin
                if (op_done_in) begin m_busy = 0; m_done = 1; end
                else if (m_cnt + 1 >= m_lim) begin m_busy = 0; m_to = 1; end
                else m_cnt++;
            end
        end
        model_live = 1;
    end

    // Compare outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (model_live && !finished) begin
            chk("R7 busy vs model", busy, m_busy);
            chk("R6 done_pulse vs model", done_pulse, m_done);
            chk("R7 timed_out vs model", timed_out, m_to);
        end
    end

    // Issue one operation and return how many sampled cycles busy stayed high.
    task automatic run_op(input int k, input int t, input int n, input int c, input int g,
                          input int done_at, input bit disturb, output int len);
        @(negedge clk);
        op_kind = 2'(k); taac_cyc = ACC_W'(t); nsac_cyc = NSAC_W'(n);
        r2w_code = 3'(c); erase_groups = EG_W'(g); op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        len = 0;
        while (busy && len < 5000) begin
            if (len == done_at) op_done_in = 1'b1;
            if (disturb && len == 2) begin
                taac_cyc = '1; r2w_code = 3'd0; op_kind = 2'd0; op_start = 1'b1;
            end
            @(negedge clk);
            op_done_in = 1'b0; op_start = 1'b0;
            len++;
        end
    endtask

    initial begin
        int len;
        repeat (3) @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 done_pulse after reset", done_pulse, 0);
        chk("R1 timed_out after reset", timed_out, 0);
        rst_n = 1'b1;

        run_op(0, 3, 2, 0, 0, -1, 0, len);
        chk("R2 read allowance", len, 50);
        chk("R7 timeout raised", timed_out, 1);
        repeat (5) @(negedge clk);
        chk("R7 timeout sticky", timed_out, 1);

        run_op(1, 3, 2, 2, 0, -1, 0, len);
        chk("R3 write allowance", len, 200);
        run_op(2, 2, 1, 1, 3, -1, 0, len);
        chk("R4 erase allowance", len, 180);

        run_op(0, 3, 2, 0, 0, 4, 0, len);
        chk("R6 early completion length", len, 5);
        chk("R6 done pulse seen", done_pulse, 1);
        chk("R6 no timeout on completion", timed_out, 0);
        @(negedge clk);
        chk("R6 done pulse single cycle", done_pulse, 0);

        run_op(0, 3, 2, 0, 0, 49, 0, len);
        chk("R6 completion on final cycle", done_pulse, 1);
        chk("R6 final-cycle no timeout", timed_out, 0);

        run_op(1, 200, 50, 5, 0, -1, 0, len);
        chk("R8 write saturation", len, 4095);
        run_op(2, 3, 2, 0, 0, -1, 0, len);
        chk("R8 zero allowance acts as one", len, 1);

        run_op(1, 3, 2, 1, 0, -1, 1, len);
        chk("R5 R9 latched limit, restart ignored", len, 100);

        @(negedge clk);
        op_done_in = 1'b1;
        @(negedge clk);
        op_done_in = 1'b0;
        chk("R9 idle completion ignored (done)", done_pulse, 0);
        chk("R9 idle completion ignored (timeout kept)", timed_out, 1);

        op_kind = 2'd3; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        chk("R10 reserved kind not accepted", busy, 0);
        chk("R10 timeout flag unchanged", timed_out, 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule